// File: doc/BRIEF.md
# Register-Programmed PLL Divider Pair

This block holds the three divider configuration bytes of a clock synthesizer. It turns them into two programmable frequency dividers. The pre-divider runs on the reference clock and gives one single-cycle pulse every Qtotal reference cycles, where Qtotal is a 7-bit field plus two. The feedback divider runs on the oscillator clock and gives one single-cycle pulse every Ptotal cycles. Ptotal is twice a 10-bit field plus four, plus one more when an odd-select bit is set. Each pulse is meant to be used as a clock enable in its own clock domain.

A host programs the bytes through a plain byte-wide write/read port. A 3-bit charge-pump setting is kept in the same register space and is only driven onto an output. Each divider picks up a new ratio only at its own terminal count, so a period that is already running always completes at its old length.

Top module: `pll_divider_regs`

## Requirements
- R1: After reset, address 0x40 reads 0xA0, addresses 0x41 and 0x42 read 0x00, `cp_setting` is 0, the pre-divide ratio is 2 and the feedback ratio is 8.
- R2: `ref_pulse` is high for exactly one `ref_clk` cycle out of every Qtotal cycles, where Qtotal = reg42[6:0] + 2 (range 2 to 129).
- R3: `fb_pulse` is high for exactly one `fb_clk` cycle out of every Ptotal cycles. Ptotal = 2*(PB+4) + PO, with PB = {reg40[1:0], reg41[7:0]} and PO = reg42[7] (range 8 to 2055).
- R4: `cp_setting` always equals reg40[4:2]. Writes to any other address leave it unchanged.
- R5: Bits 7:5 of address 0x40 always read 3'b101, whatever value was written there.
- R6: Address 0x41 reads back the last byte written to it, address 0x42 reads back the last byte written to it, and bits 4:0 of 0x40 read back the last value written to them.
- R7: Writes to any address other than 0x40, 0x41 and 0x42 change no register and no output. Reads from such addresses return 0x00.
- R8: A ratio change takes effect only at the next terminal count of the divider it affects. The period in progress completes with the old ratio, and the period after it uses the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register port clock |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, sampled on `clk` |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| ref_clk | input | 1 | Reference clock |
| fb_clk | input | 1 | Oscillator (feedback) clock |
| ref_pulse | output | 1 | Pre-divider output pulse, `ref_clk` domain |
| fb_pulse | output | 1 | Feedback divider output pulse, `fb_clk` domain |
| cp_setting | output | 3 | Charge-pump setting field |

## Verification
The assertions assume that the divider clocks take configuration bytes that are quasi-static: the bytes are stable around each terminal count. That is why the period checks compare the measured gap against the ratio latched at the previous terminal count. They also assume that reset is asserted long enough to cover all three domains. The bench drives `ref_clk`, `fb_clk` and `clk` from one 50 MHz source. This keeps each write aligned with the divider edges, so the ratio latched at each terminal count is always well defined. The bench also spaces each new ratio measurement one full terminal count after the last write.

// File: rtl/pll_divider_regs.sv
module pll_divider_regs #(
  parameter int          AW         = 8,
  parameter int          QW         = 7,
  parameter int          PBW        = 10,
  parameter logic [AW-1:0] ADDR_PB_HI = 8'h40,
  parameter logic [AW-1:0] ADDR_PB_LO = 8'h41,
  parameter logic [AW-1:0] ADDR_Q     = 8'h42,
  parameter logic [2:0]  RSV_VAL    = 3'b101
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  input  logic          reg_wr,
  output logic [7:0]    reg_rdata,
  input  logic          ref_clk,
  input  logic          fb_clk,
  output logic          ref_pulse,
  output logic          fb_pulse,
  output logic [2:0]    cp_setting
);
  localparam int QTW = QW + 1;
  localparam int PTW = PBW + 2;
  localparam logic [QTW-1:0] Q_MIN = QTW'(2);
  localparam logic [PTW-1:0] P_MIN = PTW'(8);

  logic [4:0] r40;
  logic [7:0] r41;
  logic [7:0] r42;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r40 <= '0;
      r41 <= '0;
      r42 <= '0;
    end else if (reg_wr) begin
      if (reg_addr == ADDR_PB_HI) r40 <= reg_wdata[4:0];
      if (reg_addr == ADDR_PB_LO) r41 <= reg_wdata;
      if (reg_addr == ADDR_Q)     r42 <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_PB_HI) reg_rdata = {RSV_VAL, r40};
    if (reg_addr == ADDR_PB_LO) reg_rdata = r41;
    if (reg_addr == ADDR_Q)     reg_rdata = r42;
  end

  assign cp_setting = r40[4:2];

  wire [PBW-1:0] pb      = {r40[1:0], r41};
  wire           po      = r42[7];
  wire [QTW-1:0] q_total = QTW'(r42[QW-1:0]) + QTW'(2);
  wire [PTW-1:0] p_total = PTW'((PTW'(pb) + PTW'(4)) << 1) | PTW'(po);

  logic [QTW-1:0] ref_cnt, ref_act;
  logic [PTW-1:0] fb_cnt, fb_act;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_act <= Q_MIN;
      ref_cnt <= Q_MIN - 1'b1;
    end else if (ref_cnt == '0) begin
      ref_act <= q_total;
      ref_cnt <= q_total - 1'b1;
    end else begin
      ref_cnt <= ref_cnt - 1'b1;
    end
  end

  always_ff @(posedge fb_clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_act <= P_MIN;
      fb_cnt <= P_MIN - 1'b1;
    end else if (fb_cnt == '0) begin
      fb_act <= p_total;
      fb_cnt <= p_total - 1'b1;
    end else begin
      fb_cnt <= fb_cnt - 1'b1;
    end
  end

  assign ref_pulse = (ref_cnt == '0);
  assign fb_pulse  = (fb_cnt == '0);

  logic [QTW-1:0] ref_gap;
  logic [PTW-1:0] fb_gap;
  logic           ref_seen, fb_seen;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_gap <= '0; ref_seen <= 1'b0;
    end else if (ref_pulse) begin
      ref_gap <= '0; ref_seen <= 1'b1;
    end else begin
      ref_gap <= ref_gap + 1'b1;
    end
  end

  always_ff @(posedge fb_clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_gap <= '0; fb_seen <= 1'b0;
    end else if (fb_pulse) begin
      fb_gap <= '0; fb_seen <= 1'b1;
    end else begin
      fb_gap <= fb_gap + 1'b1;
    end
  end

  AST_REF_PERIOD: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ref_pulse && ref_seen |-> QTW'(ref_gap + 1'b1) == ref_act); // R2
  AST_FB_PERIOD: assert property (@(posedge fb_clk) disable iff (!rst_n)
    fb_pulse && fb_seen |-> PTW'(fb_gap + 1'b1) == fb_act); // R3
  AST_REF_HOLD_MIDPERIOD: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !ref_pulse |=> $stable(ref_act)); // R8
  AST_FB_HOLD_MIDPERIOD: assert property (@(posedge fb_clk) disable iff (!rst_n)
    !fb_pulse |=> $stable(fb_act)); // R8
  AST_CP_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr != ADDR_PB_HI |=> $stable(cp_setting)); // R4
  AST_REF_SINGLE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ref_pulse |=> !ref_pulse); // R2
endmodule

// File: tb/sim_pll_divider_regs.sv
module sim_pll_divider_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] reg_addr = '0, reg_wdata = '0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_rdata;
  logic ref_pulse, fb_pulse;
  logic [2:0] cp_setting;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  pll_divider_regs u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rdata(reg_rdata), .ref_clk(clk), .fb_clk(clk),
    .ref_pulse(ref_pulse), .fb_pulse(fb_pulse), .cp_setting(cp_setting));

  // {a40, a41, a42, q_total, p_total, cp, read-back of 0x40}
  localparam logic [54:0] VEC [5] = '{
    {8'hA0, 8'h00, 8'h00, 8'd2,   12'd8,    3'd0, 8'hA0},
    {8'h1D, 8'h23, 8'h85, 8'd7,   12'd591,  3'd7, 8'hBD},
    {8'h48, 8'h0A, 8'h03, 8'd5,   12'd28,   3'd2, 8'hA8},
    {8'h02, 8'h00, 8'h80, 8'd2,   12'd1033, 3'd0, 8'hA2},
    {8'hFF, 8'hFF, 8'hFF, 8'd129, 12'd2055, 3'd7, 8'hBF}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    reg_addr = a;
    #1 v = int'(reg_rdata);
  endtask

  task automatic meas_ref(output int n);
    do @(negedge clk); while (!ref_pulse);
    n = 0;
    do begin @(negedge clk); n++; end while (!ref_pulse);
  endtask

  task automatic meas_fb(output int n);
    do @(negedge clk); while (!fb_pulse);
    n = 0;
    do begin @(negedge clk); n++; end while (!fb_pulse);
  endtask

  initial begin
    #(20 * 190000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int v, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'h40, v); chk("R1 rd40", v, 8'hA0);
    rd(8'h41, v); chk("R1 rd41", v, 0);
    rd(8'h42, v); chk("R1 rd42", v, 0);
    chk("R1 cp", int'(cp_setting), 0);
    meas_ref(n); chk("R1 ref ratio", n, 2);
    meas_fb(n);  chk("R1 fb ratio", n, 8);

    foreach (VEC[i]) begin
      wr(8'h40, VEC[i][54:47]);
      wr(8'h41, VEC[i][46:39]);
      wr(8'h42, VEC[i][38:31]);
      rd(8'h40, v); chk("R5 rd40", v, int'(VEC[i][7:0]));
      rd(8'h41, v); chk("R6 rd41", v, int'(VEC[i][46:39]));
      rd(8'h42, v); chk("R6 rd42", v, int'(VEC[i][38:31]));
      chk("R4 cp", int'(cp_setting), int'(VEC[i][10:8]));
      meas_ref(n); chk("R2 ref ratio", n, int'(VEC[i][30:23]));
      meas_fb(n);  chk("R3 fb ratio", n, int'(VEC[i][22:11]));
    end

    // R8: change Q from 129 to 2 at the terminal edge; running period keeps 129
    meas_ref(n); chk("R2 ref max", n, 129);
    reg_addr = 8'h42; reg_wdata = 8'h00; reg_wr = 1'b1;
    n = 0;
    do begin
      @(negedge clk); n++;
      if (n == 1) reg_wr = 1'b0;
    end while (!ref_pulse);
    chk("R8 old period completes", n, 129);
    meas_ref(n); chk("R8 new ratio", n, 2);

    // R7 unmapped addresses
    wr(8'h43, 8'h5A);
    wr(8'h00, 8'hFF);
    wr(8'hC0, 8'h13);
    rd(8'h43, v); chk("R7 rd43", v, 0);
    rd(8'h00, v); chk("R7 rd00", v, 0);
    rd(8'h3F, v); chk("R7 rd3F", v, 0);
    rd(8'h40, v); chk("R7 rd40 kept", v, 8'hBF);
    rd(8'h41, v); chk("R7 rd41 kept", v, 8'hFF);
    rd(8'h42, v); chk("R7 rd42 kept", v, 8'h00);
    chk("R7 cp kept", int'(cp_setting), 7);
    meas_ref(n); chk("R7 ref kept", n, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule